// File: doc/BRIEF.md
# Dual Selectable Timebase Tick Generator

This block produces two independent periodic tick pulses, a slow lane (A) and a fast lane (B), in the system clock domain. The rate of each lane comes from a small control register. One shared bit picks the reference family: a 32768 Hz reference or a 27 MHz reference. Two 2-bit fields pick the rate of each lane within that family. The reference clocks are not sampled directly. Each one arrives as a single-cycle enable strobe in the system clock domain, one strobe per reference period. Rates that do not divide the reference evenly are made by a phase accumulator, so the average rate over a long interval is exact.

Software programs the control register through a plain write port. The design compares the new field values against the stored ones. A lane restarts its accumulator only when a field that sets its own rate changes. A write to the clear register restarts both lanes. The tick outputs are plain one-cycle pulses meant for a downstream interrupt or event block. The block has no valid/ready stream interface, because no data flows through it.

Top module: `tbase_dual_gen`

## Requirements
- R1: While reset is held and right after it, `ctrl_rdata` reads 0x0000 and both tick outputs are low.
- R2: A write with `reg_sel`=0 stores `reg_wdata[4:0]`. Bit 4 is the family (0 = 32768 Hz reference, 1 = 27 MHz reference), bits 3:2 set the rate of lane B and bits 1:0 set the rate of lane A. `ctrl_rdata` returns these five bits with bits 15:5 reading zero. The value changes only on such a write.
- R3: In the low family, lane A runs at 8, 16, 32 or 64 Hz for a select value of 0..3, which is one tick every 4096, 2048, 1024 or 512 strobes of `ref_lo_en`.
- R4: In the low family, lane B runs at 128, 256, 512 or 1024 Hz for a select value of 0..3, which is one tick every 256, 128, 64 or 32 strobes.
- R5: In the high family, lane A runs at 12 kHz, 24 kHz, 40 kHz or 40 kHz for a select value of 0..3. After N strobes of `ref_hi_en` counted from a restart, it has produced floor(N·rate/27000000) ticks.
- R6: In the high family, lane B runs at 105, 210, 420 or 840 kHz for a select value of 0..3, and its tick count follows the same floor law.
- R7: Each tick is high for exactly one cycle. It appears in the cycle after the clock edge that samples the strobe completing the period.
- R8: A control write restarts lane A only if it changes bit 4, bit 1 or bit 0. A write that leaves those bits alone keeps the phase of lane A.
- R9: A control write restarts lane B only if it changes bit 4, bit 3 or bit 2. A write that leaves those bits alone keeps the phase of lane B.
- R10: A write with `reg_sel`=1 restarts both lanes whatever its data, and it leaves `ctrl_rdata` unchanged. The next tick of each lane comes one full period of strobes later.
- R11: When a restart falls in the same cycle as a reference strobe, the restart wins and that strobe is discarded. No tick follows that cycle.
- R12: Only the strobe of the selected family advances the lanes. Strobes of the other reference have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_lo_en | input | 1 | One-cycle strobe per 32768 Hz reference period |
| ref_hi_en | input | 1 | One-cycle strobe per 27 MHz reference period |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = clear register |
| reg_wdata | input | 16 | Write data |
| ctrl_rdata | output | 16 | Stored control value |
| tick_a | output | 1 | Lane A tick pulse |
| tick_b | output | 1 | Lane B tick pulse |

## Verification
A restart and a reference strobe can fall in the same clock edge. The bench provokes this by raising the clear write together with the strobe that would otherwise be one short of a lane B tick. It then judges the result in two ways: no pulse may appear in the next cycle, and the following tick must come exactly one full period of strobes later, not one strobe early. The bench also places a control write halfway through a period, once when it changes only the other lane's field and once when it changes the lane's own field. Tick counts over fixed windows then show whether the phase was kept or restarted.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  // Control fields; bit positions are visible to software.
  typedef struct packed {
    logic       hi_fam;  // bit 4
    logic [1:0] sel_b;   // bits 3:2
    logic [1:0] sel_a;   // bits 1:0
  } tbase_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tbase_ctrl_t);

  // Masks of the control bits that set each lane's rate.
  localparam logic [CTRL_W-1:0] LANE_A_MASK = 5'b10011;
  localparam logic [CTRL_W-1:0] LANE_B_MASK = 5'b11100;

  function automatic int unsigned lane_a_rate(input logic hi, input logic [1:0] sel);
    int unsigned r;
    if (!hi) begin
      r = 32'd8 << sel;
    end else begin
      case (sel)
        2'd0:    r = 32'd12000;
        2'd1:    r = 32'd24000;
        default: r = 32'd40000;
      endcase
    end
    return r;
  endfunction

  function automatic int unsigned lane_b_rate(input logic hi, input logic [1:0] sel);
    int unsigned r;
    if (!hi) r = 32'd128 << sel;
    else     r = 32'd105000 << sel;
    return r;
  endfunction

endpackage

// File: rtl/tbase_ctrl_regs.sv
module tbase_ctrl_regs
  import tbase_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output tbase_ctrl_t       ctrl,
  output logic [LANES-1:0]  restart
);

  localparam logic [CTRL_W-1:0] LANE_MASKS [2] = '{LANE_A_MASK, LANE_B_MASK};

  tbase_ctrl_t       ctrl_q;
  tbase_ctrl_t       ctrl_new;
  logic              ctrl_wr;
  logic              clr_wr;
  logic [CTRL_W-1:0] diff;
  logic              unused_wdata_hi;

  assign ctrl_new        = tbase_ctrl_t'(wdata[CTRL_W-1:0]);
  assign unused_wdata_hi = ^wdata[DATA_W-1:CTRL_W];
  assign ctrl_wr         = wr && !sel;
  assign clr_wr          = wr && sel;
  assign diff            = ctrl_new ^ ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_new;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_restart
    assign restart[l] = clr_wr || (ctrl_wr && ((diff & LANE_MASKS[l]) != '0));
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/tbase_rate_sel.sv
module tbase_rate_sel
  import tbase_pkg::*;
#(
  parameter int unsigned ACC_W     = 26,
  parameter int unsigned REF_LO_HZ = 32768,
  parameter int unsigned REF_HI_HZ = 27000000,
  parameter int unsigned LANE      = 0
) (
  input  tbase_ctrl_t      ctrl,
  output logic [ACC_W-1:0] incr,
  output logic [ACC_W-1:0] modulus
);

  localparam logic [ACC_W-1:0] MOD_LO = ACC_W'(REF_LO_HZ);
  localparam logic [ACC_W-1:0] MOD_HI = ACC_W'(REF_HI_HZ);

  assign modulus = ctrl.hi_fam ? MOD_HI : MOD_LO;

  if (LANE == 0) begin : g_lane_a
    assign incr = ACC_W'(lane_a_rate(ctrl.hi_fam, ctrl.sel_a));
  end else begin : g_lane_b
    assign incr = ACC_W'(lane_b_rate(ctrl.hi_fam, ctrl.sel_b));
  end

endmodule

// File: rtl/tbase_phase_acc.sv
module tbase_phase_acc #(
  parameter int unsigned ACC_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step_en,
  input  logic [ACC_W-1:0] incr,
  input  logic [ACC_W-1:0] modulus,
  output logic             tick
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic             wrap;

  // The sum stays below twice the modulus, and ACC_W leaves room for that.
  assign sum  = acc_q + incr;
  assign wrap = sum >= modulus;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else if (step_en) begin
      acc_q <= wrap ? (sum - modulus) : sum;
      tick  <= wrap;
    end else begin
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/tbase_dual_gen.sv
module tbase_dual_gen
  import tbase_pkg::*;
#(
  parameter int unsigned REF_LO_HZ = 32768,
  parameter int unsigned REF_HI_HZ = 27000000,
  parameter int unsigned DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_lo_en,
  input  logic              ref_hi_en,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] ctrl_rdata,
  output logic              tick_a,
  output logic              tick_b
);

  localparam int unsigned LANES  = 2;
  localparam int unsigned REF_MX = (REF_HI_HZ > REF_LO_HZ) ? REF_HI_HZ : REF_LO_HZ;
  localparam int unsigned ACC_W  = $clog2(REF_MX) + 1;

  tbase_ctrl_t      ctrl;
  logic [LANES-1:0] restart;
  logic [LANES-1:0] ticks;
  logic             step;

  tbase_ctrl_regs #(.DATA_W(DATA_W), .LANES(LANES)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .ctrl    (ctrl),
    .restart (restart)
  );

  // Both lanes follow the shared family bit.
  assign step = ctrl.hi_fam ? ref_hi_en : ref_lo_en;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ACC_W-1:0] incr;
    logic [ACC_W-1:0] modulus;

    tbase_rate_sel #(
      .ACC_W(ACC_W), .REF_LO_HZ(REF_LO_HZ), .REF_HI_HZ(REF_HI_HZ), .LANE(l)
    ) u_rate (
      .ctrl    (ctrl),
      .incr    (incr),
      .modulus (modulus)
    );

    tbase_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart[l]),
      .step_en (step),
      .incr    (incr),
      .modulus (modulus),
      .tick    (ticks[l])
    );
  end

  assign ctrl_rdata = DATA_W'(ctrl);
  assign tick_a     = ticks[0];
  assign tick_b     = ticks[1];

endmodule

// File: rtl/tbase_dual_gen_chk.sv
module tbase_dual_gen_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_lo_en,
  input logic              ref_hi_en,
  input logic              reg_wr,
  input logic              reg_sel,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] ctrl_rdata,
  input logic              tick_a,
  input logic              tick_b
);

  p_tick_a_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tick_a |-> $past(ctrl_rdata[4] ? ref_hi_en : ref_lo_en));

  p_tick_b_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tick_b |-> $past(ctrl_rdata[4] ? ref_hi_en : ref_lo_en));

  p_pulse_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_a |=> !tick_a);

  p_pulse_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_b |=> !tick_b);

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && !reg_sel) |=> $stable(ctrl_rdata));

  p_clear_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel) |=> (!tick_a && !tick_b));

  p_reload_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && ((reg_wdata[4] != ctrl_rdata[4]) ||
                            (reg_wdata[1:0] != ctrl_rdata[1:0]))) |=> !tick_a);

  p_reload_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel && ((reg_wdata[4] != ctrl_rdata[4]) ||
                            (reg_wdata[3:2] != ctrl_rdata[3:2]))) |=> !tick_b);

endmodule

bind tbase_dual_gen tbase_dual_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ref_lo_en  (ref_lo_en),
  .ref_hi_en  (ref_hi_en),
  .reg_wr     (reg_wr),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .ctrl_rdata (ctrl_rdata),
  .tick_a     (tick_a),
  .tick_b     (tick_b)
);

// File: tb/test_tbase_dual_gen.sv
`timescale 1ns/1ps
module test_tbase_dual_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_lo_en = 1'b0;
  logic        ref_hi_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        tick_a;
  logic        tick_b;

  int n_tests = 0;
  int n_fail  = 0;
  int cnt_a;
  int cnt_b;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tbase_dual_gen i_tbase_dual_gen (
    .clk(clk), .rst_n(rst_n), .ref_lo_en(ref_lo_en), .ref_hi_en(ref_hi_en),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ctrl_rdata(ctrl_rdata), .tick_a(tick_a), .tick_b(tick_b)
  );

  // Vector table: control value, strobe family (1 = high), strobe count, expected A, B.
  localparam int NV = 9;
  localparam int V_CTRL [NV] = '{'h00, 'h0F, 'h06, 'h10, 'h1F, 'h19, 'h13, 'h10, 'h00};
  localparam int V_HI   [NV] = '{0,    0,    0,    1,    1,    1,    1,    0,    1};
  localparam int V_N    [NV] = '{4096, 1024, 2048, 27000, 27000, 27000, 2700, 5000, 5000};
  localparam int V_EA   [NV] = '{1,    2,    2,    12,   40,   24,   4,    0,    0};
  localparam int V_EB   [NV] = '{16,   32,   16,   105,  840,  420,  10,   0,    0};
  localparam string V_REQ [NV] = '{"R3", "R4", "R3", "R5", "R6", "R6", "R5", "R12", "R12"};

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run(input bit hi, input int n);
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_a += int'(tick_a); cnt_b += int'(tick_b);
      ref_hi_en = hi; ref_lo_en = !hi;
    end
    @(negedge clk);
    cnt_a += int'(tick_a); cnt_b += int'(tick_b);
    ref_hi_en = 1'b0; ref_lo_en = 1'b0;
  endtask

  initial begin
    #(190000 * 8);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ctrl in reset", int'(ctrl_rdata), 0);
    check("R1 ticks in reset", int'(tick_a) + int'(tick_b), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctrl after reset", int'(ctrl_rdata), 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      wr_reg(1'b0, 16'(V_CTRL[v]));
      wr_reg(1'b1, 16'h0000);
      run(V_HI[v] != 0, V_N[v]);
      check({V_REQ[v], " lane A count"}, cnt_a, V_EA[v]);
      check({V_REQ[v], " lane B count"}, cnt_b, V_EB[v]);
    end

    // R2: upper bits read zero
    wr_reg(1'b0, 16'hFFFF);
    check("R2 readback", int'(ctrl_rdata), 'h1F);

    // R7: pulse timing and width, lane B period 32
    wr_reg(1'b0, 16'h000F);
    wr_reg(1'b1, 16'h0000);
    run(1'b0, 31);
    check("R7 no early tick", cnt_b, 0);
    @(negedge clk); ref_lo_en = 1'b1;
    @(negedge clk); ref_lo_en = 1'b0;
    check("R7 tick after 32nd strobe", int'(tick_b), 1);
    @(negedge clk);
    check("R7 tick one cycle wide", int'(tick_b), 0);

    // R8: lane A restart; lane B keeps phase (R9 keep)
    wr_reg(1'b1, 16'h0000);
    run(1'b0, 500);
    check("R8 lane A before write", cnt_a, 0);
    check("R4 lane B before write", cnt_b, 15);
    wr_reg(1'b0, 16'h000E);
    run(1'b0, 1023);
    check("R8 lane A restarted", cnt_a, 0);
    check("R9 lane B phase kept", cnt_b, 32);
    run(1'b0, 1);
    check("R8 lane A full period", cnt_a, 1);

    // R9: lane B restart
    wr_reg(1'b0, 16'h000F);
    wr_reg(1'b1, 16'h0000);
    run(1'b0, 20);
    wr_reg(1'b0, 16'h000B);
    run(1'b0, 63);
    check("R9 lane B restarted", cnt_b, 0);
    run(1'b0, 1);
    check("R9 lane B full period", cnt_b, 1);

    // R10: clear with nonzero data
    wr_reg(1'b0, 16'h000F);
    wr_reg(1'b1, 16'h0000);
    run(1'b0, 20);
    wr_reg(1'b1, 16'hFFFF);
    check("R10 ctrl unchanged by clear", int'(ctrl_rdata), 'h0F);
    run(1'b0, 31);
    check("R10 lane B restarted", cnt_b, 0);
    run(1'b0, 1);
    check("R10 lane B full period", cnt_b, 1);

    // R11: clear in the same cycle as a strobe
    wr_reg(1'b1, 16'h0000);
    run(1'b0, 31);
    @(negedge clk);
    ref_lo_en = 1'b1; reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h0000;
    @(negedge clk);
    ref_lo_en = 1'b0; reg_wr = 1'b0;
    check("R11 no tick on collision", int'(tick_b), 0);
    run(1'b0, 31);
    check("R11 strobe discarded", cnt_b, 0);
    run(1'b0, 1);
    check("R11 full period after", cnt_b, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule